// File: doc/BRIEF.md
# Multi-standard video sync generator

This block derives the horizontal and vertical timing of a camera pipeline from its pixel clock. A horizontal counter runs across one line whose length in clocks depends on both the sensor width and the frame standard; every time it wraps, a line counter steps on, and the line counter wraps after 525 or 625 lines. From the two counts the block produces drive pulses for the sensor front end, a horizontal reference window for the luminance/chrominance path, a composite sync and a field flag. All of them are registered.

The block can free-run or follow an external timing source. In follow mode, an external horizontal reset loads the horizontal counter with a programmable 10-bit value instead of clearing it. An external vertical reset clears the line counter. The composite sync output comes either from the internal sync or from an external sync input, and in both cases it lags its source by one clock. All configuration is static level inputs.

Top module: `video_sync_gen`

## Requirements
- R1: With `lines_625`=0, `hcount_out` counts up by one per clock and wraps to 0 after the last clock of a line. The line length is 606, 806, 858 or 910 clocks for `sensor_sel` 00, 01, 10 and 11.
- R2: With `lines_625`=1, the line length is 618, 824, 864 or 908 clocks for `sensor_sel` 00, 01, 10 and 11. A count at or above the last position wraps to 0 on the next clock.
- R3: `vcount_out` advances by one in the same clock in which `hcount_out` wraps. It wraps to 0 after 524 when `lines_625`=0 and after 624 when `lines_625`=1, and it never changes otherwise in free-run mode.
- R4: `field_out` is 1 exactly when the line count one clock earlier was at least 263 (525 lines) or at least 313 (625 lines).
- R5: `hd_out` is high one clock after a horizontal count below HD_WIDTH. `vd_out` is high one clock after a line count below VD_LINES. Both are inverted when `hv_invert`=1.
- R6: `href_out` is high one clock after a horizontal count in the range HREF_START to HREF_END-1.
- R7: The internal sync is registered from the counts. In lines below VSYNC_LINES it is high for all but the last CSYNC_WIDTH clocks of the line; in other lines it is high for counts below CSYNC_WIDTH. With `ext_sync_sel`=0, `csync_out` equals the internal sync delayed by one clock.
- R8: With `ext_sync_sel`=1, `csync_out` equals `sync_in` delayed by one clock.
- R9: With `slave_mode`=1, a high `hrst_in` makes `hcount_out` equal `h_preset` on the next clock. The line count does not advance in that clock.
- R10: With `slave_mode`=1, a high `vrst_in` clears `vcount_out` on the next clock. With `slave_mode`=0, `hrst_in` and `vrst_in` have no effect on either count.
- R11: While `rst_n` is low, both counts and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sensor_sel | input | 2 | Sensor width code (00..11) |
| lines_625 | input | 1 | 0: 525-line frame, 1: 625-line frame |
| slave_mode | input | 1 | 0: free-run, 1: follow external resets |
| hv_invert | input | 1 | Inverts hd_out and vd_out |
| ext_sync_sel | input | 1 | 0: internal composite sync, 1: sync_in |
| h_preset | input | 10 | Value loaded by an external horizontal reset |
| hrst_in | input | 1 | External horizontal reset |
| vrst_in | input | 1 | External vertical reset |
| sync_in | input | 1 | External composite sync |
| hcount_out | output | 10 | Horizontal count |
| vcount_out | output | 10 | Line count |
| hd_out | output | 1 | Horizontal drive pulse |
| vd_out | output | 1 | Vertical drive pulse |
| href_out | output | 1 | Horizontal reference window |
| csync_out | output | 1 | Composite sync |
| field_out | output | 1 | Field flag |

## Verification
The hardest behaviour to reach is the vertical one: the line wrap at 524 or 624 and the field change at the half-frame. In free-run mode, reaching them takes hundreds of thousands of clocks. The stimulus therefore uses follow mode. It pulses the horizontal reset every other clock with the preset set to the last position of the line, so each line lasts two clocks and a whole frame passes in about a thousand clocks. A reference model sends one expected output set per clock into a queue, and each set is compared against the design half a cycle later.

// File: rtl/video_sync_gen.sv
module video_sync_gen #(
  parameter int HW          = 10,
  parameter int VW          = 10,
  parameter int HD_WIDTH    = 32,
  parameter int VD_LINES    = 3,
  parameter int HREF_START  = 100,
  parameter int HREF_END    = 150,
  parameter int CSYNC_WIDTH = 50,
  parameter int VSYNC_LINES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sensor_sel,
  input  logic          lines_625,
  input  logic          slave_mode,
  input  logic          hv_invert,
  input  logic          ext_sync_sel,
  input  logic [HW-1:0] h_preset,
  input  logic          hrst_in,
  input  logic          vrst_in,
  input  logic          sync_in,
  output logic [HW-1:0] hcount_out,
  output logic [VW-1:0] vcount_out,
  output logic          hd_out,
  output logic          vd_out,
  output logic          href_out,
  output logic          csync_out,
  output logic          field_out
);
  localparam logic [HW-1:0] HD_END  = HW'(HD_WIDTH);
  localparam logic [HW-1:0] HR_LO   = HW'(HREF_START);
  localparam logic [HW-1:0] HR_HI   = HW'(HREF_END);
  localparam logic [HW:0]   CS_W    = (HW+1)'(CSYNC_WIDTH);
  localparam logic [VW-1:0] VD_END  = VW'(VD_LINES);
  localparam logic [VW-1:0] VS_END  = VW'(VSYNC_LINES);

  function automatic logic [HW-1:0] line_last(input logic [1:0] s, input logic l625);
    case ({l625, s})
      3'b000:  return HW'(605);
      3'b001:  return HW'(805);
      3'b010:  return HW'(857);
      3'b011:  return HW'(909);
      3'b100:  return HW'(617);
      3'b101:  return HW'(823);
      3'b110:  return HW'(863);
      default: return HW'(907);
    endcase
  endfunction

  logic [HW-1:0] h_cnt, h_last;
  logic [VW-1:0] v_cnt, v_last, v_half;
  logic          h_load, v_clear, h_wrap, sync_int_r, sync_next;

  assign h_last  = line_last(sensor_sel, lines_625);
  assign v_last  = lines_625 ? VW'(624) : VW'(524);
  assign v_half  = lines_625 ? VW'(313) : VW'(263);
  assign h_load  = slave_mode & hrst_in;
  assign v_clear = slave_mode & vrst_in;
  assign h_wrap  = h_cnt >= h_last;

  assign sync_next = (v_cnt < VS_END) ? (({1'b0, h_cnt} + CS_W) <= {1'b0, h_last})
                                      : (h_cnt < CS_W[HW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      if (h_load)      h_cnt <= h_preset;
      else if (h_wrap) h_cnt <= '0;
      else             h_cnt <= h_cnt + 1'b1;
      if (v_clear)               v_cnt <= '0;
      else if (h_wrap && !h_load) v_cnt <= (v_cnt >= v_last) ? '0 : v_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_out     <= 1'b0;
      vd_out     <= 1'b0;
      href_out   <= 1'b0;
      sync_int_r <= 1'b0;
      csync_out  <= 1'b0;
      field_out  <= 1'b0;
    end else begin
      hd_out     <= (h_cnt < HD_END) ^ hv_invert;
      vd_out     <= (v_cnt < VD_END) ^ hv_invert;
      href_out   <= (h_cnt >= HR_LO) && (h_cnt < HR_HI);
      sync_int_r <= sync_next;
      csync_out  <= ext_sync_sel ? sync_in : sync_int_r;
      field_out  <= v_cnt >= v_half;
    end
  end

  assign hcount_out = h_cnt;
  assign vcount_out = v_cnt;
endmodule

// File: rtl/video_sync_gen_chk.sv
module video_sync_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slave_mode,
  input logic       hrst_in,
  input logic       lines_625,
  input logic       ext_sync_sel,
  input logic       sync_in,
  input logic       sync_int,
  input logic [9:0] h_preset,
  input logic [9:0] hcount_out,
  input logic [9:0] vcount_out,
  input logic       csync_out,
  input logic       field_out
);
  assert_h_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount_out != 10'd0 && !$past(slave_mode && hrst_in)) |-> hcount_out == $past(hcount_out) + 10'd1);

  assert_v_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vcount_out <= 10'd624);

  assert_v_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!slave_mode) && hcount_out != 10'd0) |-> $stable(vcount_out));

  assert_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    field_out == ($past(vcount_out) >= ($past(lines_625) ? 10'd313 : 10'd263)));

  assert_int_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ext_sync_sel) |-> csync_out == $past(sync_int));

  assert_ext_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync_sel |=> csync_out == $past(sync_in));

  assert_preset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && hrst_in) |=> hcount_out == $past(h_preset));
endmodule

bind video_sync_gen video_sync_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .hrst_in(hrst_in),
  .lines_625(lines_625), .ext_sync_sel(ext_sync_sel), .sync_in(sync_in),
  .sync_int(sync_int_r), .h_preset(h_preset), .hcount_out(hcount_out),
  .vcount_out(vcount_out), .csync_out(csync_out), .field_out(field_out)
);

// File: tb/video_sync_gen_tb.sv
`timescale 1ns/1ps
module video_sync_gen_tb;
  localparam int HD_W = 32, VD_L = 3, HR_S = 100, HR_E = 150, CS_W = 50, VS_L = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sensor_sel = 2'b00;
  logic       lines_625 = 1'b0, slave_mode = 1'b0, hv_invert = 1'b0, ext_sync_sel = 1'b0;
  logic [9:0] h_preset = '0;
  logic       hrst_in = 1'b0, vrst_in = 1'b0, sync_in = 1'b0;
  logic [9:0] hcount_out, vcount_out;
  logic       hd_out, vd_out, href_out, csync_out, field_out;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  video_sync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .sensor_sel(sensor_sel), .lines_625(lines_625),
    .slave_mode(slave_mode), .hv_invert(hv_invert), .ext_sync_sel(ext_sync_sel),
    .h_preset(h_preset), .hrst_in(hrst_in), .vrst_in(vrst_in), .sync_in(sync_in),
    .hcount_out(hcount_out), .vcount_out(vcount_out), .hd_out(hd_out), .vd_out(vd_out),
    .href_out(href_out), .csync_out(csync_out), .field_out(field_out)
  );

  function automatic int exp_last(input logic [1:0] s, input logic l625);
    int t525 [4] = '{605, 805, 857, 909};
    int t625 [4] = '{617, 823, 863, 907};
    return l625 ? t625[s] : t525[s];
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  typedef struct packed {
    logic [9:0] hc; logic [9:0] vc;
    logic hd, vd, hr, cs, fld;
  } exp_t;
  exp_t q[$];
  exp_t e;

  int   mh, mv;
  logic m_hd, m_vd, m_hr, m_si, m_cs, m_fld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mh <= 0; mv <= 0;
      m_hd <= 0; m_vd <= 0; m_hr <= 0; m_si <= 0; m_cs <= 0; m_fld <= 0;
    end else begin
      int last, vl;
      last = exp_last(sensor_sel, lines_625);
      vl   = lines_625 ? 624 : 524;
      if (slave_mode && hrst_in) mh <= int'(h_preset);
      else if (mh >= last)       mh <= 0;
      else                       mh <= mh + 1;
      if (slave_mode && vrst_in) mv <= 0;
      else if (mh >= last && !(slave_mode && hrst_in)) mv <= (mv >= vl) ? 0 : mv + 1;
      m_hd  <= (mh < HD_W) ^ hv_invert;
      m_vd  <= (mv < VD_L) ^ hv_invert;
      m_hr  <= (mh >= HR_S) && (mh < HR_E);
      m_si  <= (mv < VS_L) ? (mh + CS_W <= last) : (mh < CS_W);
      m_cs  <= ext_sync_sel ? sync_in : m_si;
      m_fld <= mv >= (lines_625 ? 313 : 263);
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      q.push_back('{hc: 10'(mh), vc: 10'(mv), hd: m_hd, vd: m_vd, hr: m_hr, cs: m_cs, fld: m_fld});
    end
  end

  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      cmp("R1 R2 R9 hcount", hcount_out, e.hc);
      cmp("R3 R10 vcount", vcount_out, e.vc);
      cmp("R4 field", field_out, e.fld);
      cmp("R5 hd", hd_out, e.hd);
      cmp("R5 vd", vd_out, e.vd);
      cmp("R6 href", href_out, e.hr);
      cmp("R7 R8 csync", csync_out, e.cs);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep(input int lines);
    h_preset   = 10'(exp_last(sensor_sel, lines_625));
    slave_mode = 1'b1;
    repeat (lines) begin
      hrst_in = 1'b1; @(negedge clk);
      hrst_in = 1'b0; @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    run(3);
    cmp("R11 reset hcount", hcount_out, 0);
    cmp("R11 reset vcount", vcount_out, 0);
    cmp("R11 reset hd", hd_out, 0);
    cmp("R11 reset csync", csync_out, 0);
    cmp("R11 reset field", field_out, 0);
    rst_n = 1'b1;

    for (int c = 0; c < 8; c++) begin
      int last;
      sensor_sel = 2'(c);
      lines_625  = c[2];
      last = exp_last(sensor_sel, lines_625);
      run(5);
      while (hcount_out != 10'(last)) @(negedge clk);
      @(negedge clk);
      cmp(lines_625 ? "R2 line wrap" : "R1 line wrap", hcount_out, 0);
      run(last + 20);
    end

    hv_invert = 1'b1;
    run(1000);

    ext_sync_sel = 1'b1;
    for (int i = 0; i < 300; i++) begin
      sync_in = (i % 3 == 0) || (i % 7 == 2);
      @(negedge clk);
    end
    ext_sync_sel = 1'b0;
    sync_in = 1'b0;

    while (hcount_out != 10'd100) @(negedge clk);
    h_preset = 10'd5;
    begin
      int v0;
      v0 = vcount_out;
      hrst_in = 1'b1; vrst_in = 1'b1;
      @(negedge clk);
      hrst_in = 1'b0; vrst_in = 1'b0;
      cmp("R10 master ignores hrst", hcount_out, 101);
      cmp("R10 master ignores vrst", vcount_out, v0);
    end

    slave_mode = 1'b1;
    h_preset = 10'd300;
    hrst_in = 1'b1;
    @(negedge clk);
    hrst_in = 1'b0;
    cmp("R9 preset load", hcount_out, 300);
    run(10);

    sensor_sel = 2'b00; lines_625 = 1'b0; hv_invert = 1'b0;
    vrst_in = 1'b1; @(negedge clk); vrst_in = 1'b0;
    sweep(300);
    cmp("R4 field after half frame 525", field_out, 1);
    sweep(240);
    cmp("R3 frame wrap 525", vcount_out < 20, 1);

    sensor_sel = 2'b11; lines_625 = 1'b1; hv_invert = 1'b1;
    vrst_in = 1'b1; @(negedge clk); vrst_in = 1'b0;
    cmp("R10 slave vrst clears", vcount_out, 0);
    sweep(312);
    cmp("R4 field before half frame 625", field_out, 0);
    sweep(2);
    cmp("R4 field after half frame 625", field_out, 1);
    sweep(320);

    slave_mode = 1'b0;
    run(1200);
    summary();
  end
endmodule